// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block reorders the bytes of a single time-division multiplexed stream. Each frame carries 24 slots of one 8-bit voice channel each. A speech store keeps the bytes of a frame, a connection map names the source or destination slot of each byte, and a slot counter supplies the sequential address. Each slot gives the speech store one write and one read.

Two addressing methods share the same connection map, and the `mode` input selects between them:

- **Sequential write, random read (mode 0):** incoming slot `i` is stored at address `i`. Output slot `j` reads the address held in map entry `j`.
- **Random write, sequential read (mode 1):** incoming slot `i` is stored at the address held in map entry `i`. Output slot `j` reads address `j`.

The speech store has two banks that alternate at every frame boundary. The output of a frame is therefore always built from the complete previous frame. Software loads the map through a write port into a shadow copy, and the shadow copy becomes active at the next frame boundary. The mode input is sampled at the same boundary.

A small sequencer controls when output is produced. It starts in `ST_HUNT` and waits for frame sync. Transition `T_LOCK` moves it to `ST_FILL` on the first slot that carries sync, and the first frame is then stored without producing output. Transition `T_PRIME` moves it to `ST_RUN` at the next frame boundary. `ST_RUN` is kept until reset (`T_HOLD`).

Top module: `tsi_switch`

## Requirements
- R1: After reset `dout` is 0, `dout_valid` is 0, the mode is sequential-write (0), and every map entry `k` holds `k`, so each slot passes through to the same slot.
- R2: Slots offered before the first slot with `fsync`=1 are ignored: they produce no `dout_valid`, and their bytes never appear at the output.
- R3: The frame that begins at the first sync is stored with `dout_valid` held at 0. From the next frame boundary on, each accepted slot gives `dout_valid`=1 for exactly one cycle, one clock after its strobe. `dout_valid` is 0 in cycles without a strobe.
- R4: In mode 0, output slot `j` of frame F+1 carries input slot `map[j]` of frame F.
- R5: In mode 1, input slot `i` of frame F appears at output slot `map[i]` of frame F+1.
- R6: The speech store is double-buffered. Every output slot carries a byte of the previous frame, including output slots that come earlier in the frame than their source slot.
- R7: The slot counter wraps from 23 to 0 without `fsync`. A wrap is a frame boundary in the same way as a sync.
- R8: A slot with `fsync`=1 is slot 0, even in the middle of a frame. The following slots count on from 1.
- R9: A map write is applied at the next frame boundary. A write in the same cycle as a frame-start slot is applied at the boundary after it.
- R10: `mode` is sampled only on frame-start slots. A change in mid-frame takes effect at the next frame boundary.
- R11: A map write is discarded if `cm_addr` ≥ 24 or `cm_data` ≥ 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = sequential write/random read, 1 = random write/sequential read |
| slot_valid | input | 1 | Strobe: `din` holds one slot byte |
| fsync | input | 1 | Marks the strobed slot as slot 0 of a frame |
| din | input | 8 | Incoming slot byte |
| cm_we | input | 1 | Map write enable |
| cm_addr | input | 5 | Map entry index |
| cm_data | input | 5 | Slot index to store in the entry |
| dout | output | 8 | Outgoing slot byte |
| dout_valid | output | 1 | `dout` holds a new output slot |

## Verification
Each output byte is due one clock after the input strobe of the same slot position in the following frame. The bench therefore samples `dout` and `dout_valid` on the falling edge right after the strobe edge, and checks `dout_valid` again in the idle cycle that follows. Map writes and mode changes take effect one frame boundary later. For this reason the bench predicts per frame: it stores the previous frame's bytes, its map and its mode, and it latches its own copy of the shadow map at each frame start. It then computes each expected byte from the addressing rule of each mode.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } tsi_state_e;

    // Addressing method
    typedef enum logic {
        MODE_SEQ_WR  = 1'b0,
        MODE_RAND_WR = 1'b1
    } tsi_mode_e;

endpackage

// File: rtl/tsi_seq_fsm.sv
module tsi_seq_fsm
    import tsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_valid,
    input  logic       fsync,
    input  logic       frame_start,
    output tsi_state_e st,
    output logic       accept,
    output logic       rd_en
);

    tsi_state_e st_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HUNT;
        else        st <= st_nxt;
    end

    // Transitions: T_LOCK, T_PRIME, T_HOLD
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_HUNT: if (slot_valid && fsync) st_nxt = ST_FILL;  // T_LOCK (R2)
            ST_FILL: if (frame_start)         st_nxt = ST_RUN;   // T_PRIME (R3)
            ST_RUN:                           st_nxt = ST_RUN;   // T_HOLD
            default:                          st_nxt = ST_HUNT;
        endcase
    end

    // Outputs
    always_comb begin
        accept = 1'b0;
        rd_en  = 1'b0;
        unique case (st)
            ST_HUNT: begin
                accept = slot_valid && fsync;
                rd_en  = 1'b0;
            end
            ST_FILL: begin
                accept = slot_valid;
                rd_en  = slot_valid && frame_start;
            end
            ST_RUN: begin
                accept = slot_valid;
                rd_en  = slot_valid;
            end
            default: begin
                accept = 1'b0;
                rd_en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tsi_slot_counter.sv
module tsi_slot_counter #(
    parameter int SLOTS = 24,
    localparam int IDXW = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            fsync,
    output logic [IDXW-1:0] idx,
    output logic            frame_start,
    output logic [IDXW-1:0] cnt_q
);

    localparam logic [IDXW-1:0] LAST = IDXW'(SLOTS - 1);

    // Sync forces slot 0 (R8); otherwise the expected next index is used
    assign idx         = fsync ? '0 : cnt_q;
    assign frame_start = accept && (idx == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= (idx == LAST) ? '0 : idx + 1'b1;  // wrap (R7)
        end
    end

endmodule

// File: rtl/tsi_ctrl_mem.sv
module tsi_ctrl_mem #(
    parameter int SLOTS = 24,
    localparam int IDXW = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cm_we,
    input  logic [IDXW-1:0]       cm_addr,
    input  logic [IDXW-1:0]       cm_data,
    input  logic                  frame_start,
    input  logic [IDXW-1:0]       idx,
    output logic [IDXW-1:0]       entry,
    output logic [SLOTS*IDXW-1:0] map_flat
);

    localparam logic [IDXW:0] LIMIT = (IDXW + 1)'(SLOTS);

    logic [IDXW-1:0] shadow [SLOTS];
    logic [IDXW-1:0] active [SLOTS];
    logic            wr_ok;

    // Out-of-range address or data is discarded (R11)
    assign wr_ok = cm_we && ({1'b0, cm_addr} < LIMIT) && ({1'b0, cm_data} < LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SLOTS; k++) begin
                shadow[k] <= IDXW'(k);  // identity (R1)
                active[k] <= IDXW'(k);
            end
        end else begin
            if (wr_ok) shadow[cm_addr] <= cm_data;
            if (frame_start) begin
                for (int k = 0; k < SLOTS; k++) active[k] <= shadow[k];  // R9
            end
        end
    end

    // The frame-start slot already uses the map it installs
    assign entry = frame_start ? shadow[idx] : active[idx];

    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
        assign map_flat[g*IDXW +: IDXW] = active[g];
    end

endmodule

// File: rtl/tsi_speech_mem.sv
module tsi_speech_mem #(
    parameter int SLOTS = 24,
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             we,
    input  logic [IDXW-1:0]  waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDXW-1:0]  raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [2][SLOTS];
    logic             bank_q;
    logic             wbank;

    // Banks swap on each frame start (R6)
    assign wbank = frame_start ? ~bank_q : bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n)  bank_q <= 1'b0;
        else if (we) bank_q <= wbank;
    end

    always_ff @(posedge clk) begin
        if (we) mem[wbank][waddr] <= wdata;
    end

    // Read from the bank holding the complete previous frame
    assign rdata = mem[~wbank][raddr];

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int SLOTS = 24,
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic             slot_valid,
    input  logic             fsync,
    input  logic [WIDTH-1:0] din,
    input  logic             cm_we,
    input  logic [IDXW-1:0]  cm_addr,
    input  logic [IDXW-1:0]  cm_data,
    output logic [WIDTH-1:0] dout,
    output logic             dout_valid
);

    tsi_state_e            st;
    logic                  accept;
    logic                  rd_en;
    logic [IDXW-1:0]       idx;
    logic                  frame_start;
    logic [IDXW-1:0]       cnt_q;
    logic [IDXW-1:0]       entry;
    logic [SLOTS*IDXW-1:0] map_flat;
    tsi_mode_e             mode_q;
    tsi_mode_e             mode_eff;
    logic [IDXW-1:0]       waddr;
    logic [IDXW-1:0]       raddr;
    logic [WIDTH-1:0]      rdata;

    tsi_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_valid  (slot_valid),
        .fsync       (fsync),
        .frame_start (frame_start),
        .st          (st),
        .accept      (accept),
        .rd_en       (rd_en)
    );

    tsi_slot_counter #(.SLOTS(SLOTS)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .fsync       (fsync),
        .idx         (idx),
        .frame_start (frame_start),
        .cnt_q       (cnt_q)
    );

    tsi_ctrl_mem #(.SLOTS(SLOTS)) u_cmem (
        .clk         (clk),
        .rst_n       (rst_n),
        .cm_we       (cm_we),
        .cm_addr     (cm_addr),
        .cm_data     (cm_data),
        .frame_start (frame_start),
        .idx         (idx),
        .entry       (entry),
        .map_flat    (map_flat)
    );

    // Mode sampled at frame starts only (R10)
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= MODE_SEQ_WR;
        else if (frame_start) mode_q <= tsi_mode_e'(mode);
    end

    assign mode_eff = frame_start ? tsi_mode_e'(mode) : mode_q;

    // R4 / R5 address selection
    always_comb begin
        if (mode_eff == MODE_SEQ_WR) begin
            waddr = idx;
            raddr = entry;
        end else begin
            waddr = entry;
            raddr = idx;
        end
    end

    tsi_speech_mem #(.SLOTS(SLOTS), .WIDTH(WIDTH)) u_smem (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .we          (accept),
        .waddr       (waddr),
        .wdata       (din),
        .raddr       (raddr),
        .rdata       (rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= rd_en;
            if (rd_en) dout <= rdata;
        end
    end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
#(
    parameter int SLOTS = 24,
    localparam int IDXW = $clog2(SLOTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  slot_valid,
    input logic                  fsync,
    input logic                  dout_valid,
    input tsi_state_e            st,
    input logic [IDXW-1:0]       cnt_q,
    input logic                  frame_start,
    input tsi_mode_e             mode_q,
    input logic [SLOTS*IDXW-1:0] map_flat
);

    a_r2_hunt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HUNT && !(slot_valid && fsync)) |=> (st == ST_HUNT));

    a_r3_valid_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> $past(slot_valid));

    a_r3_fill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL && !frame_start) |=> !dout_valid);

    a_r7_counter_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !fsync && st != ST_HUNT && cnt_q == IDXW'(SLOTS - 1)) |=> (cnt_q == '0));

    a_r8_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && fsync) |=> (cnt_q == IDXW'(1)));

    a_r9_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(map_flat));

    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(mode_q));

endmodule

bind tsi_switch tsi_switch_chk #(.SLOTS(SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_valid  (slot_valid),
    .fsync       (fsync),
    .dout_valid  (dout_valid),
    .st          (st),
    .cnt_q       (cnt_q),
    .frame_start (frame_start),
    .mode_q      (mode_q),
    .map_flat    (map_flat)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;

    localparam int N = 24;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode;
    logic       slot_valid;
    logic       fsync;
    logic [7:0] din;
    logic       cm_we;
    logic [4:0] cm_addr;
    logic [4:0] cm_data;
    logic [7:0] dout;
    logic       dout_valid;

    always #10 clk = ~clk;

    tsi_switch u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .slot_valid(slot_valid),
        .fsync(fsync), .din(din), .cm_we(cm_we), .cm_addr(cm_addr),
        .cm_data(cm_data), .dout(dout), .dout_valid(dout_valid)
    );

    int  total = 0;
    int  bad   = 0;
    bit  finished = 0;

    // Reference state, kept per frame
    int       sh [N];
    int       prev_map [N];
    int       cur_map [N];
    bit       prev_mode;
    bit       cur_mode;
    logic [7:0] prev_in [N];
    logic [7:0] cur_in [N];
    logic [7:0] img [N];
    bit       running   = 0;
    bit       skip_data = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int j);
        return 8'((seed * 37 + j * 11 + 5) & 255);
    endfunction

    function automatic bit map_ok(input int a, input int d);
        return (a < N) && (d < N);  // R11 acceptance rule
    endfunction

    task automatic do_slot(input logic [7:0] b, input bit fs, input bit we,
                           input int wa, input int wd,
                           output logic [7:0] got, output bit gv);
        slot_valid = 1'b1; din = b; fsync = fs;
        cm_we = we; cm_addr = 5'(wa); cm_data = 5'(wd);
        @(posedge clk); @(negedge clk);
        got = dout; gv = dout_valid;
        slot_valid = 1'b0; fsync = 1'b0; cm_we = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R3 idle cycle dout_valid", int'(dout_valid), 0);
    endtask

    task automatic cm_write(input int a, input int d);
        cm_we = 1'b1; cm_addr = 5'(a); cm_data = 5'(d);
        @(posedge clk); @(negedge clk);
        cm_we = 1'b0;
        if (map_ok(a, d)) sh[a] = d;
    endtask

    task automatic load_rotation(input int r);
        for (int k = 0; k < N; k++) cm_write(k, (k + r) % N);
    endtask

    // One frame of n slots; wslot/mslot < 0 disable the mid-frame write/mode change
    task automatic run_frame(input int seed, input bit fs, input int n,
                             input int wslot, input int wa, input int wd,
                             input int mslot, input bit mval, input string tag);
        logic [7:0] got;
        bit         gv;
        int         addr;
        // image of the previous frame as the write rule of its mode stored it
        for (int a = 0; a < N; a++) img[a] = 8'h00;
        for (int i = 0; i < N; i++) begin
            if (prev_mode == 1'b0) img[i] = prev_in[i];
            else                   img[prev_map[i]] = prev_in[i];
        end
        cur_mode = mode;
        for (int k = 0; k < N; k++) cur_map[k] = sh[k];
        for (int j = 0; j < n; j++) begin
            if (j == mslot) mode = mval;
            do_slot(pat(seed, j), fs && (j == 0), (j == wslot), wa, wd, got, gv);
            if (j == wslot && map_ok(wa, wd)) sh[wa] = wd;
            cur_in[j] = pat(seed, j);
            if (running) begin
                chk($sformatf("R3 %s valid slot %0d", tag, j), int'(gv), 1);
                if (!skip_data) begin
                    addr = (cur_mode == 1'b0) ? cur_map[j] : j;
                    chk($sformatf("%s data slot %0d", tag, j), int'(got), int'(img[addr]));
                end
            end else begin
                chk($sformatf("R3 fill frame valid slot %0d", j), int'(gv), 0);
            end
        end
        for (int k = 0; k < N; k++) begin
            prev_in[k]  = cur_in[k];
            prev_map[k] = cur_map[k];
        end
        prev_mode = cur_mode;
        skip_data = (n < N);
        running   = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        bit         gv;
        rst_n = 1'b0; mode = 1'b0; slot_valid = 1'b0; fsync = 1'b0;
        din = '0; cm_we = 1'b0; cm_addr = '0; cm_data = '0;
        for (int k = 0; k < N; k++) begin
            sh[k] = k; prev_map[k] = k; prev_in[k] = 8'h00;
        end
        prev_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset dout", int'(dout), 0);
        chk("R1 reset dout_valid", int'(dout_valid), 0);

        // R2: bytes before the first sync are ignored
        for (int j = 0; j < 5; j++) begin
            do_slot(8'hE0 + 8'(j), 1'b0, 1'b0, 0, 0, got, gv);
            chk("R2 hunt dout_valid", int'(gv), 0);
        end

        // R3 fill frame, then R1 identity pass-through
        run_frame(1, 1'b1, N, -1, 0, 0, -1, 1'b0, "R2");
        run_frame(2, 1'b1, N, -1, 0, 0, -1, 1'b0, "R1 identity");

        // R7: free-running frames without sync, R4 rotation
        load_rotation(5);
        run_frame(3, 1'b0, N, -1, 0, 0, -1, 1'b0, "R7 wrap");
        run_frame(4, 1'b0, N, -1, 0, 0, -1, 1'b0, "R4 seq-wr");

        // R10 / R5: switch to random write
        mode = 1'b1;
        run_frame(5, 1'b1, N, -1, 0, 0, -1, 1'b0, "R10 switch");
        run_frame(6, 1'b1, N, -1, 0, 0, -1, 1'b0, "R5 rand-wr");

        // R9 mid-frame map write, R10 mid-frame mode change
        run_frame(7, 1'b1, N, 7, 0, 13, 12, 1'b0, "R9 midframe");
        run_frame(8, 1'b1, N, -1, 0, 0, -1, 1'b0, "R10 midframe");
        // R9: write on the frame-start slot itself
        run_frame(9, 1'b1, N, 0, 0, 5, -1, 1'b0, "R9 startslot");
        run_frame(10, 1'b1, N, -1, 0, 0, -1, 1'b0, "R9 after");

        // R11: out-of-range writes discarded
        cm_write(30, 3);
        cm_write(2, 27);
        run_frame(11, 1'b1, N, -1, 0, 0, -1, 1'b0, "R11 ignored");
        run_frame(12, 1'b1, N, -1, 0, 0, -1, 1'b0, "R11 ignored");

        // R8: sync in mid-frame restarts the count
        run_frame(13, 1'b1, 10, -1, 0, 0, -1, 1'b0, "R8 partial");
        run_frame(14, 1'b1, N, -1, 0, 0, -1, 1'b0, "R8 resync");
        run_frame(15, 1'b1, N, -1, 0, 0, -1, 1'b0, "R8 after resync");

        // R6 sweep: every rotation in both modes
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r < N; r++) begin
                load_rotation(r);
                mode = 1'(m);
                run_frame(100 + m * N + r, 1'b1, N, -1, 0, 0, -1, 1'b0,
                          (m == 0) ? "R6 R4 sweep" : "R6 R5 sweep");
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule